// File: doc/BRIEF.md
# Recovery Block Sequencer

This block is the control state machine for one hardware recovery-block unit. When asked to enter the unit, it first requests that a checkpoint be saved. It then starts a set of alternate implementations one at a time, primary first. It waits for an acceptance-test verdict on each result. A passing result causes the checkpoint to be discarded and a success pulse to be issued, together with the index of the alternate that was accepted. A failing result causes the checkpoint to be restored and the next alternate to be started. The exceptions are when the deadline has run out or no alternate is left; in that case a failure exception is raised.

A deadline counter is loaded from a cycle budget when the unit is entered. If the budget runs out while an alternate is still running, that alternate is aborted and the attempt counts as failed. The block does not store the checkpoint data, and it does not implement the alternates. Checkpoint storage is driven through save, restore and discard strobes that share one acknowledge. Alternates are driven through a start strobe with an index and a separate acknowledge.

Top module: `rb_sequencer`

## Requirements
- R1: A request on `enter_req` while idle produces a one-cycle `ckpt_save` pulse in the next cycle. No alternate is started until `ckpt_ack` has been seen after that pulse.
- R2: Alternates start in ascending index order, beginning at index 0. Each start is a one-cycle `alt_start` pulse with `alt_sel` giving the index (0 … N_ALT-1).
- R3: If `at_done` is high with `at_pass` high, a one-cycle `ckpt_discard` pulse follows. In the cycle after the matching `ckpt_ack`, `ok_pulse` is high for one cycle and `ok_idx` holds the accepted index.
- R4: If `at_done` is high with `at_pass` low, the deadline has not expired and the index is below N_ALT-1, a one-cycle `ckpt_restore` pulse follows. After its `ckpt_ack`, the next alternate is started.
- R5: If `at_done` is high with `at_pass` low, and either the index is N_ALT-1 or the deadline has expired, `fail_pulse` is high for one cycle in the next cycle. No restore is issued.
- R6: The deadline counter is loaded with `budget` on the entry clock edge. It counts as expired in every cycle that follows at least `budget` clock edges after entry; a budget of 0 is expired at once. While an alternate runs without `at_done`, expiry gives a one-cycle `alt_abort`, followed by `fail_pulse` in the next cycle.
- R7: Every strobe (save, restore, discard, start) lasts exactly one cycle. The sequencer then waits for its acknowledge: `ckpt_ack` for checkpoint strobes, `alt_ack` for start.
- R8: `enter_req` is ignored while the sequencer is busy. No `ckpt_save` occurs after completion unless a new request arrives while idle.
- R9: After reset, all strobes and result pulses are low and `alt_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_req | input | 1 | Request to run the unit |
| budget | input | BUDGET_W | Deadline in clock cycles, sampled at entry |
| ckpt_save | output | 1 | Checkpoint save strobe |
| ckpt_restore | output | 1 | Checkpoint restore strobe |
| ckpt_discard | output | 1 | Checkpoint discard strobe |
| ckpt_ack | input | 1 | Checkpoint operation complete |
| alt_start | output | 1 | Start strobe for the selected alternate |
| alt_sel | output | IDX_W | Index of the current alternate |
| alt_ack | input | 1 | Alternate accepted the start |
| alt_abort | output | 1 | Abort the running alternate on deadline expiry |
| at_done | input | 1 | Acceptance test verdict valid |
| at_pass | input | 1 | Acceptance test verdict |
| ok_pulse | output | 1 | Unit completed with an accepted result |
| ok_idx | output | IDX_W | Index of the accepted alternate |
| fail_pulse | output | 1 | Failure exception |

## Verification
A corrupted state register shows up at the ports within one or two cycles. Typical symptoms are a strobe that lasts more than a cycle, a start with the wrong `alt_sel`, or a result pulse with no acknowledge before it. A wrong alternate index appears on the next `alt_start`, or on `ok_idx` with the success pulse. A deadline counter that is off by even one cycle moves `alt_abort` to a different cycle. It can also turn a restore into a failure exception, because the bench drives verdicts exactly at the expiry boundary. A busy sequencer that accepts a request would show a `ckpt_save` pulse when none is expected.

// File: rtl/rb_sequencer.sv
module rb_sequencer #(
  parameter int N_ALT    = 3,
  parameter int BUDGET_W = 16,
  localparam int IDX_W   = (N_ALT > 1) ? $clog2(N_ALT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enter_req,
  input  logic [BUDGET_W-1:0] budget,
  output logic                ckpt_save,
  output logic                ckpt_restore,
  output logic                ckpt_discard,
  input  logic                ckpt_ack,
  output logic                alt_start,
  output logic [IDX_W-1:0]    alt_sel,
  input  logic                alt_ack,
  output logic                alt_abort,
  input  logic                at_done,
  input  logic                at_pass,
  output logic                ok_pulse,
  output logic [IDX_W-1:0]    ok_idx,
  output logic                fail_pulse
);

  typedef enum logic [3:0] {
    IDLE, SAVE, SAVE_W, START, START_W, RUN,
    RESTORE, RESTORE_W, DISCARD, DISCARD_W
  } st_t;

  st_t                 st, st_n;
  logic [IDX_W-1:0]    idx;
  logic [BUDGET_W-1:0] cnt;
  logic                expired, last;

  assign expired      = (cnt == '0);
  assign last         = (idx == IDX_W'(N_ALT - 1));
  assign ckpt_save    = (st == SAVE);
  assign ckpt_restore = (st == RESTORE);
  assign ckpt_discard = (st == DISCARD);
  assign alt_start    = (st == START);
  assign alt_abort    = (st == RUN) && !at_done && expired;
  assign alt_sel      = idx;
  assign ok_idx       = idx;

  always_comb begin
    st_n = st;
    unique case (st)
      IDLE:      if (enter_req) st_n = SAVE;
      SAVE:      st_n = SAVE_W;
      SAVE_W:    if (ckpt_ack) st_n = START;
      START:     st_n = START_W;
      START_W:   if (alt_ack) st_n = RUN;
      RUN:
        if (at_done) begin
          if (at_pass)              st_n = DISCARD;
          else if (expired || last) st_n = IDLE;
          else                      st_n = RESTORE;
        end else if (expired) begin
          st_n = IDLE;
        end
      RESTORE:   st_n = RESTORE_W;
      RESTORE_W: if (ckpt_ack) st_n = START;
      DISCARD:   st_n = DISCARD_W;
      DISCARD_W: if (ckpt_ack) st_n = IDLE;
      default:   st_n = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      idx        <= '0;
      cnt        <= '0;
      ok_pulse   <= 1'b0;
      fail_pulse <= 1'b0;
    end else begin
      st         <= st_n;
      ok_pulse   <= (st == DISCARD_W) && ckpt_ack;
      fail_pulse <= (st == RUN) && (st_n == IDLE);
      if (st == IDLE) begin
        if (enter_req) begin
          idx <= '0;
          cnt <= budget;
        end
      end else begin
        if (!expired) cnt <= cnt - 1'b1;
        if (st == RUN && st_n == RESTORE) idx <= idx + 1'b1;
      end
    end
  end

  a_r1_save_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && enter_req) |=> ckpt_save);

  a_r7_single_cycle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_save || ckpt_restore || ckpt_discard || alt_start) |=>
      !(ckpt_save || ckpt_restore || ckpt_discard || alt_start));

  a_r7_exclusive_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ckpt_save, ckpt_restore, ckpt_discard, alt_start, alt_abort, ok_pulse, fail_pulse}));

  a_r3_ok_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_pulse) |-> $past(ckpt_ack));

  a_r6_abort_then_fail: assert property (@(posedge clk) disable iff (!rst_n)
    alt_abort |=> fail_pulse);

  a_r5_no_restore_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && at_done && !at_pass && last) |=> (fail_pulse && !ckpt_restore));

  a_r8_busy_ignores_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && enter_req) |=> !ckpt_save);

  a_r2_start_index_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START_W) |-> $stable(alt_sel));

endmodule

// File: tb/rb_sequencer_tb_top.sv
`timescale 1ns/1ps
module rb_sequencer_tb_top;
  localparam int N  = 3;
  localparam int BW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enter_req = 1'b0;
  logic [BW-1:0] budget = '0;
  logic          ckpt_save, ckpt_restore, ckpt_discard;
  logic          ckpt_ack = 1'b0;
  logic          alt_start;
  logic [IW-1:0] alt_sel;
  logic          alt_ack = 1'b0;
  logic          alt_abort;
  logic          at_done = 1'b0, at_pass = 1'b0;
  logic          ok_pulse, fail_pulse;
  logic [IW-1:0] ok_idx;

  int n_chk = 0, n_bad = 0, m = 0;
  bit done_all = 1'b0;

  always #2 clk = ~clk;

  rb_sequencer #(.N_ALT(N), .BUDGET_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .budget(budget),
    .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore), .ckpt_discard(ckpt_discard),
    .ckpt_ack(ckpt_ack), .alt_start(alt_start), .alt_sel(alt_sel), .alt_ack(alt_ack),
    .alt_abort(alt_abort), .at_done(at_done), .at_pass(at_pass),
    .ok_pulse(ok_pulse), .ok_idx(ok_idx), .fail_pulse(fail_pulse));

  task automatic check(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", r, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    m++;
    @(negedge clk);
  endtask

  function automatic bit expect_fail(input int mm, input int b, input int idx);
    return (mm >= b) || (idx == N - 1);
  endfunction

  task automatic ack_ckpt(input int dly, input string r);
    step();
    check({r, " strobe one cycle"}, int'(ckpt_save | ckpt_restore | ckpt_discard), 0);
    for (int i = 0; i < dly; i++) step();
    ckpt_ack = 1'b1;
    step();
    ckpt_ack = 1'b0;
  endtask

  // pass_mask bit i: alternate i passes; dl[i]: cycles before verdict (large = hang)
  task automatic trial(input int b, input bit [N-1:0] pass_mask, input int dl[N], input bit noise);
    int idx;
    bit fin;
    budget = BW'(b);
    enter_req = 1'b1;
    m = -1;
    step();
    enter_req = 1'b0;
    check("R1 save after entry", int'(ckpt_save), 1);
    check("R1 no start during save", int'(alt_start), 0);
    ack_ckpt($urandom_range(0, 2), "R7 save");
    idx = 0;
    fin = 1'b0;
    while (!fin) begin
      check("R2 start pulse", int'(alt_start), 1);
      check("R2 start index", int'(alt_sel), idx);
      step();
      check("R7 start one cycle", int'(alt_start), 0);
      for (int i = 0, lim = $urandom_range(0, 2); i < lim; i++) step();
      alt_ack = 1'b1;
      step();
      alt_ack = 1'b0;
      for (int c = 0; ; c++) begin
        if (m >= b) begin
          enter_req = 1'b0;
          check("R6 abort on expiry", int'(alt_abort), 1);
          step();
          check("R6 fail after abort", int'(fail_pulse), 1);
          fin = 1'b1;
          break;
        end
        check("R6 no early abort", int'(alt_abort), 0);
        if (c >= dl[idx]) begin
          enter_req = 1'b0;
          at_done = 1'b1;
          at_pass = pass_mask[idx];
          if (pass_mask[idx]) begin
            step();
            at_done = 1'b0;
            check("R3 discard on pass", int'(ckpt_discard), 1);
            ack_ckpt($urandom_range(0, 2), "R7 discard");
            check("R3 ok pulse", int'(ok_pulse), 1);
            check("R3 ok index", int'(ok_idx), idx);
            fin = 1'b1;
          end else if (expect_fail(m, b, idx)) begin
            step();
            at_done = 1'b0;
            check("R5 fail pulse", int'(fail_pulse), 1);
            check("R5 no restore", int'(ckpt_restore), 0);
            fin = 1'b1;
          end else begin
            step();
            at_done = 1'b0;
            check("R4 restore on fail", int'(ckpt_restore), 1);
            check("R4 no fail yet", int'(fail_pulse), 0);
            ack_ckpt($urandom_range(0, 2), "R7 restore");
            idx++;
          end
          break;
        end
        enter_req = noise;
        step();
      end
    end
    at_pass = 1'b0;
    step();
    check("R8 no save without idle request", int'(ckpt_save), 0);
    check("R3 ok pulse single", int'(ok_pulse), 0);
    check("R5 fail pulse single", int'(fail_pulse), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int dl[N];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 reset save", int'(ckpt_save), 0);
    check("R9 reset start", int'(alt_start), 0);
    check("R9 reset sel", int'(alt_sel), 0);
    check("R9 reset ok", int'(ok_pulse), 0);
    check("R9 reset fail", int'(fail_pulse), 0);
    rst_n = 1'b1;
    step();
    // directed: primary passes
    dl = '{1, 1, 1};
    trial(1000, 3'b001, dl, 1'b0);
    // directed: last alternate passes after two restores
    dl = '{0, 2, 3};
    trial(1000, 3'b100, dl, 1'b1);
    // directed: all fail
    dl = '{0, 0, 0};
    trial(1000, 3'b000, dl, 1'b0);
    // directed: zero budget aborts at once
    dl = '{5, 5, 5};
    trial(0, 3'b111, dl, 1'b0);
    // directed: primary hangs, small budget
    dl = '{1000, 0, 0};
    trial(12, 3'b111, dl, 1'b1);
    // directed: failure exactly at and just before expiry
    for (int b = 6; b < 14; b++) begin
      dl = '{2, 2, 2};
      trial(b, 3'b000, dl, 1'b0);
    end
    for (int t = 0; t < 60; t++) begin
      int b;
      b = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 30) : 1000;
      foreach (dl[i]) dl[i] = ($urandom_range(0, 9) == 0) ? 1000 : $urandom_range(0, 6);
      if (b == 1000) foreach (dl[i]) if (dl[i] == 1000) dl[i] = 6;
      trial(b, 3'($urandom_range(0, 7)), dl, 1'($urandom_range(0, 1)));
    end
    done_all = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule